// File: doc/BRIEF.md
# Hypervisor-Aware Interrupt Routing Selector

This block picks the interrupt a hart should take next when it runs with three interrupt target levels: machine, hypervisor-supervisor (HS) and virtual-supervisor (VS). Each cycle it takes these inputs:

- the current privilege and the virtualization bit;
- the machine and supervisor global-enable bits;
- the pending and per-cause enable vectors;
- two delegation masks, one from machine to supervisor and one from hypervisor to VS.

It splits every enabled pending cause into one of three routing classes. It qualifies each cause with the global enable of the level that class is routed to. It then reports the lowest-numbered cause that survives.

The result is a registered valid flag, a cause index and a target level. Trap-entry logic samples these on the next cycle. VS software, timer and external causes need no special path. Like every other cause, they are routed by the two masks alone, so a VS cause that is not delegated to VS lands in HS.

All pins are plain control and status signals. The output is a level that follows the inputs with one cycle of latency, so there is no valid/ready handshake and no back-pressure: the consumer samples the output whenever it needs it.

Top module: `irq_route_sel`

## Requirements
- R1: A cause is a candidate only when its bit is set in both the pending and the enable vector. A pending cause whose enable bit is clear is never reported.
- R2: The privilege input encodes user as 0, supervisor as 1 and machine as 3. The machine-level enable is on when privilege is below machine, or when privilege is machine with the machine global-enable bit set.
- R3: The supervisor-level enable is on when privilege is user, or when privilege is supervisor with the supervisor global-enable bit set.
- R4: The HS-level enable is on whenever virtualization is active, whatever the supervisor-level enable, and otherwise equals the supervisor-level enable.
- R5: The VS-level enable is on only when virtualization is active and the supervisor-level enable is on.
- R6: Routing uses the two masks and the target output encodes the class. A candidate clear in the machine delegation mask goes to machine (target 0) under the machine-level enable. One set in the machine mask but clear in the hypervisor mask goes to HS (target 1) under the HS-level enable. One set in both masks goes to VS (target 2) under the VS-level enable.
- R7: When several causes are eligible, the reported cause is the lowest-numbered eligible bit index.
- R8: The VS causes at bits 2, 6 and 10 follow the same rules as any other cause. When delegated from machine but not from hypervisor, they are reported with target HS.
- R9: With no eligible cause, valid is 0, the cause index is 0 and the target is 0.
- R10: Outputs are registered, reflecting the inputs sampled at the previous rising clock edge. A synchronous active-high reset clears valid, index and target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Virtualization active |
| mgie_i | input | 1 | Machine global interrupt enable |
| sgie_i | input | 1 | Supervisor global interrupt enable |
| pend_i | input | W | Pending cause vector |
| en_i | input | W | Per-cause enable vector |
| mdeleg_i | input | W | Machine-to-supervisor delegation mask |
| hdeleg_i | input | W | Hypervisor-to-VS delegation mask |
| irq_valid_o | output | 1 | An eligible cause exists |
| irq_cause_o | output | $clog2(W) | Index of the selected cause |
| irq_tgt_o | output | 2 | Target level: 0 machine, 1 HS, 2 VS |

## Verification
Every result is due exactly one rising edge after the inputs that produce it, with no other delay anywhere in the block. The driver task applies one input set on a falling edge and pushes the expected triple into a queue. The monitor pops one entry one time unit after each following rising edge and compares it, so each comparison lands in the cycle its result is due. Reset is handled the same way: a cycle driven with reset high expects all-zero outputs on the next edge.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [1:0] PRIV_USER  = 2'd0;
  localparam logic [1:0] PRIV_SUPER = 2'd1;
  localparam logic [1:0] PRIV_MACH  = 2'd3;

  typedef enum logic [1:0] {
    TGT_M  = 2'd0,
    TGT_HS = 2'd1,
    TGT_VS = 2'd2
  } tgt_e;

  typedef struct packed {
    logic m;
    logic hs;
    logic vs;
  } lvl_en_t;

endpackage

// File: rtl/irq_level_enables.sv
module irq_level_enables
  import irq_route_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       mgie_i,
  input  logic       sgie_i,
  output lvl_en_t    lvl_en_o
);

  logic m_on;
  logic s_on;

  always_comb begin
    m_on = (priv_i < PRIV_MACH) || ((priv_i == PRIV_MACH) && mgie_i);
    s_on = (priv_i < PRIV_SUPER) || ((priv_i == PRIV_SUPER) && sgie_i);
    lvl_en_o.m  = m_on;
    lvl_en_o.hs = virt_i | s_on;
    lvl_en_o.vs = virt_i & s_on;
  end

endmodule

// File: rtl/irq_route_classifier.sv
module irq_route_classifier
  import irq_route_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] mdeleg_i,
  input  logic [W-1:0] hdeleg_i,
  input  lvl_en_t      lvl_en_i,
  output logic [W-1:0] cls_m_o,
  output logic [W-1:0] cls_hs_o,
  output logic [W-1:0] elig_o
);

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic cand;
      logic to_m;
      logic to_hs;
      logic to_vs;
      assign cand  = pend_i[g] & en_i[g];
      assign to_m  = ~mdeleg_i[g];
      assign to_hs = mdeleg_i[g] & ~hdeleg_i[g];
      assign to_vs = mdeleg_i[g] & hdeleg_i[g];
      assign cls_m_o[g]  = to_m;
      assign cls_hs_o[g] = to_hs;
      assign elig_o[g]   = cand & ((to_m  & lvl_en_i.m)  |
                                   (to_hs & lvl_en_i.hs) |
                                   (to_vs & lvl_en_i.vs));
    end
  endgenerate

endmodule

// File: rtl/irq_lowest_picker.sv
module irq_lowest_picker #(
  parameter int W    = 64,
  parameter int IDXW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]    vec_i,
  output logic            found_o,
  output logic [IDXW-1:0] idx_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDXW'(i);
      end
    end
  end

endmodule

// File: rtl/irq_route_sel.sv
module irq_route_sel
  import irq_route_pkg::*;
#(
  parameter int W    = 64,
  parameter int IDXW = (W > 1) ? $clog2(W) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  input  logic            mgie_i,
  input  logic            sgie_i,
  input  logic [W-1:0]    pend_i,
  input  logic [W-1:0]    en_i,
  input  logic [W-1:0]    mdeleg_i,
  input  logic [W-1:0]    hdeleg_i,
  output logic            irq_valid_o,
  output logic [IDXW-1:0] irq_cause_o,
  output logic [1:0]      irq_tgt_o
);

  lvl_en_t         lvl_en;
  logic [W-1:0]    cls_m;
  logic [W-1:0]    cls_hs;
  logic [W-1:0]    elig;
  logic            found;
  logic [IDXW-1:0] pick;
  tgt_e            tgt_d;

  irq_level_enables u_en (
    .priv_i   (priv_i),
    .virt_i   (virt_i),
    .mgie_i   (mgie_i),
    .sgie_i   (sgie_i),
    .lvl_en_o (lvl_en)
  );

  irq_route_classifier #(.W(W)) u_cls (
    .pend_i   (pend_i),
    .en_i     (en_i),
    .mdeleg_i (mdeleg_i),
    .hdeleg_i (hdeleg_i),
    .lvl_en_i (lvl_en),
    .cls_m_o  (cls_m),
    .cls_hs_o (cls_hs),
    .elig_o   (elig)
  );

  irq_lowest_picker #(.W(W), .IDXW(IDXW)) u_pick (
    .vec_i   (elig),
    .found_o (found),
    .idx_o   (pick)
  );

  always_comb begin
    if (!found)            tgt_d = TGT_M;
    else if (cls_m[pick])  tgt_d = TGT_M;
    else if (cls_hs[pick]) tgt_d = TGT_HS;
    else                   tgt_d = TGT_VS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid_o <= 1'b0;
      irq_cause_o <= '0;
      irq_tgt_o   <= TGT_M;
    end else begin
      irq_valid_o <= found;
      irq_cause_o <= found ? pick : '0;
      irq_tgt_o   <= tgt_d;
    end
  end

endmodule

// File: rtl/irq_route_sel_chk.sv
module irq_route_sel_chk #(
  parameter int W    = 64,
  parameter int IDXW = (W > 1) ? $clog2(W) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      priv_i,
  input logic            virt_i,
  input logic            mgie_i,
  input logic            sgie_i,
  input logic [W-1:0]    pend_i,
  input logic [W-1:0]    en_i,
  input logic [W-1:0]    mdeleg_i,
  input logic [W-1:0]    hdeleg_i,
  input logic            irq_valid_o,
  input logic [IDXW-1:0] irq_cause_o,
  input logic [1:0]      irq_tgt_o
);

  logic [W-1:0] cand_q;
  logic [W-1:0] md_q;
  logic [W-1:0] hd_q;

  always_ff @(posedge clk) begin
    cand_q <= pend_i & en_i;
    md_q   <= mdeleg_i;
    hd_q   <= hdeleg_i;
  end

  // R1: a reported cause was pending and enabled one cycle earlier
  assert_cand_source_R1: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> cand_q[irq_cause_o]);

  // R1: no candidates at all means nothing reported next cycle
  assert_no_cand_idle_R1: assert property (@(posedge clk) disable iff (rst)
    ((pend_i & en_i) == '0) |=> !irq_valid_o);

  // R4: virtualized, an HS-routed candidate always yields a report
  assert_hs_when_virt_R4: assert property (@(posedge clk) disable iff (rst)
    (virt_i && ((pend_i & en_i & mdeleg_i & ~hdeleg_i) != '0)) |=> irq_valid_o);

  // R2: below machine, an undelegated candidate always yields a report
  assert_m_below_R2: assert property (@(posedge clk) disable iff (rst)
    ((priv_i != 2'd3) && ((pend_i & en_i & ~mdeleg_i) != '0)) |=> irq_valid_o);

  // R6: target agrees with the masks of the selected cause
  assert_tgt_class_R6: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |->
      ((irq_tgt_o == 2'd0) ? !md_q[irq_cause_o] :
       (irq_tgt_o == 2'd1) ? (md_q[irq_cause_o] && !hd_q[irq_cause_o]) :
       (irq_tgt_o == 2'd2) ? (md_q[irq_cause_o] && hd_q[irq_cause_o]) : 1'b0));

  // R9: idle outputs are all zero
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !irq_valid_o |-> (irq_cause_o == '0 && irq_tgt_o == 2'd0));

  // R10: reset clears the registered outputs (checked on the following cycle)
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;
  always @(negedge clk) begin
    if (rst_q === 1'b1)
      assert_reset_clear_R10: assert (irq_valid_o == 1'b0 && irq_cause_o == '0 && irq_tgt_o == 2'd0);
  end

  logic unused_ok;
  assign unused_ok = ^{priv_i, virt_i, mgie_i, sgie_i};

endmodule

bind irq_route_sel irq_route_sel_chk #(.W(W), .IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .priv_i      (priv_i),
  .virt_i      (virt_i),
  .mgie_i      (mgie_i),
  .sgie_i      (sgie_i),
  .pend_i      (pend_i),
  .en_i        (en_i),
  .mdeleg_i    (mdeleg_i),
  .hdeleg_i    (hdeleg_i),
  .irq_valid_o (irq_valid_o),
  .irq_cause_o (irq_cause_o),
  .irq_tgt_o   (irq_tgt_o)
);

// File: tb/irq_route_sel_tb.sv
module irq_route_sel_tb;

  localparam int W    = 64;
  localparam int IDXW = 6;

  typedef struct {
    logic            v;
    logic [IDXW-1:0] idx;
    logic [1:0]      tgt;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      priv_i = 2'd3;
  logic            virt_i = 1'b0;
  logic            mgie_i = 1'b0;
  logic            sgie_i = 1'b0;
  logic [W-1:0]    pend_i = '0;
  logic [W-1:0]    en_i = '0;
  logic [W-1:0]    mdeleg_i = '0;
  logic [W-1:0]    hdeleg_i = '0;
  logic            irq_valid_o;
  logic [IDXW-1:0] irq_cause_o;
  logic [1:0]      irq_tgt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  irq_route_sel #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .priv_i(priv_i), .virt_i(virt_i),
    .mgie_i(mgie_i), .sgie_i(sgie_i), .pend_i(pend_i), .en_i(en_i),
    .mdeleg_i(mdeleg_i), .hdeleg_i(hdeleg_i),
    .irq_valid_o(irq_valid_o), .irq_cause_o(irq_cause_o), .irq_tgt_o(irq_tgt_o)
  );

  // Expected result from the requirement text
  function automatic exp_t model(input logic r, input logic [1:0] p, input logic vt,
                                 input logic mg, input logic sg,
                                 input logic [W-1:0] pd, input logic [W-1:0] en,
                                 input logic [W-1:0] md, input logic [W-1:0] hd);
    exp_t e;
    logic m_ok, s_ok, hs_ok, vs_ok, ok;
    e.v = 0; e.idx = 0; e.tgt = 0; e.tag = "";
    if (r) return e;
    m_ok  = (p == 2'd0) || (p == 2'd1) || (p == 2'd2) || (p == 2'd3 && mg);
    s_ok  = (p == 2'd0) || (p == 2'd1 && sg);
    hs_ok = vt || s_ok;
    vs_ok = vt && s_ok;
    for (int i = 0; i < W; i++) begin
      if (!e.v && pd[i] && en[i]) begin
        if (!md[i])      ok = m_ok;
        else if (!hd[i]) ok = hs_ok;
        else             ok = vs_ok;
        if (ok) begin
          e.v   = 1;
          e.idx = IDXW'(i);
          e.tgt = !md[i] ? 2'd0 : (!hd[i] ? 2'd1 : 2'd2);
        end
      end
    end
    return e;
  endfunction

  task automatic drive(input string tag, input logic r, input logic [1:0] p,
                       input logic vt, input logic mg, input logic sg,
                       input logic [W-1:0] pd, input logic [W-1:0] en,
                       input logic [W-1:0] md, input logic [W-1:0] hd);
    exp_t e;
    @(negedge clk);
    rst = r; priv_i = p; virt_i = vt; mgie_i = mg; sgie_i = sg;
    pend_i = pd; en_i = en; mdeleg_i = md; hdeleg_i = hd;
    e = model(r, p, vt, mg, sg, pd, en, md, hd);
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: one result is due one time unit after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (irq_valid_o !== e.v || irq_cause_o !== e.idx || irq_tgt_o !== e.tgt) begin
          fails++;
          $display("FAIL %s: got v=%0b idx=%0d tgt=%0d expected v=%0b idx=%0d tgt=%0d",
                   e.tag, irq_valid_o, irq_cause_o, irq_tgt_o, e.v, e.idx, e.tgt);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  localparam logic [W-1:0] Z = '0;
  localparam logic [W-1:0] ONES = '1;

  function automatic logic [W-1:0] b(input int i);
    logic [W-1:0] x;
    x = '0;
    x[i] = 1'b1;
    return x;
  endfunction

  initial begin
    // R10: reset state
    drive("R10 reset", 1, 2'd0, 0, 1, 1, ONES, ONES, Z, Z);
    drive("R10 reset", 1, 2'd0, 0, 1, 1, ONES, ONES, Z, Z);
    // R1: pending but not enabled
    drive("R1 disabled", 0, 2'd0, 0, 0, 0, b(5), Z, Z, Z);
    drive("R1 enabled", 0, 2'd0, 0, 0, 0, b(5), b(5), Z, Z);
    // R2: machine level
    drive("R2 M mgie=0", 0, 2'd3, 0, 0, 1, b(7), b(7), Z, Z);
    drive("R2 M mgie=1", 0, 2'd3, 0, 1, 0, b(7), b(7), Z, Z);
    drive("R2 S below M", 0, 2'd1, 0, 0, 0, b(7), b(7), Z, Z);
    // R3: supervisor level, not virtualized
    drive("R3 S sgie=0", 0, 2'd1, 0, 1, 0, b(9), b(9), b(9), Z);
    drive("R3 S sgie=1", 0, 2'd1, 0, 0, 1, b(9), b(9), b(9), Z);
    drive("R3 U sgie=0", 0, 2'd0, 0, 0, 0, b(9), b(9), b(9), Z);
    drive("R3 M blocks S", 0, 2'd3, 0, 1, 1, b(9), b(9), b(9), Z);
    // R4: HS forced on under virtualization
    drive("R4 virt S sgie=0", 0, 2'd1, 1, 0, 0, b(9), b(9), b(9), Z);
    drive("R4 virt U", 0, 2'd0, 1, 0, 0, b(12), b(12), b(12), Z);
    // R5: VS level
    drive("R5 virt S sgie=0", 0, 2'd1, 1, 0, 0, b(10), b(10), b(10), b(10));
    drive("R5 virt S sgie=1", 0, 2'd1, 1, 0, 1, b(10), b(10), b(10), b(10));
    drive("R5 virt U", 0, 2'd0, 1, 0, 0, b(10), b(10), b(10), b(10));
    drive("R5 nonvirt U", 0, 2'd0, 0, 1, 1, b(10), b(10), b(10), b(10));
    // R6: three classes, one at a time
    drive("R6 class M", 0, 2'd0, 1, 0, 1, b(20), b(20), Z, ONES);
    drive("R6 class HS", 0, 2'd0, 1, 0, 1, b(20), b(20), b(20), Z);
    drive("R6 class VS", 0, 2'd0, 1, 0, 1, b(20), b(20), b(20), b(20));
    // R8: VS causes reach HS when not delegated to VS
    drive("R8 bit2 HS", 0, 2'd0, 0, 0, 0, b(2), b(2), b(2), Z);
    drive("R8 bit6 HS virt", 0, 2'd1, 1, 0, 0, b(6), b(6), b(6), Z);
    drive("R8 bit10 M", 0, 2'd1, 1, 0, 0, b(10), b(10), Z, Z);
    // R7: lowest eligible
    drive("R7 lowest", 0, 2'd0, 0, 0, 0, b(1) | b(3), ONES, Z, Z);
    drive("R7 skip inelig", 0, 2'd0, 0, 0, 0, b(1) | b(4), ONES, b(1), b(1));
    drive("R7 top bit", 0, 2'd0, 0, 0, 0, b(63), ONES, Z, Z);
    drive("R7 mixed", 0, 2'd1, 1, 0, 0, b(2) | b(6) | b(10) | b(40), ONES,
          b(2) | b(6) | b(10), b(2) | b(6));
    // R9: nothing eligible after a valid cycle
    drive("R9 idle", 0, 2'd3, 0, 0, 0, b(30), b(30), Z, Z);
    // R10: mid-run reset
    drive("R10 pre", 0, 2'd0, 0, 0, 0, b(33), b(33), Z, Z);
    drive("R10 midrun", 1, 2'd0, 0, 0, 0, b(33), b(33), Z, Z);
    drive("R10 release", 0, 2'd0, 0, 0, 0, b(33), b(33), Z, Z);
    // Mixed patterns (R6, R7)
    for (int n = 0; n < 300; n++) begin
      logic [1:0] p;
      p = 2'($urandom_range(0, 2));
      if (p == 2'd2) p = 2'd3;
      drive("R6 R7 mixed", 0, p, 1'($urandom), 1'($urandom), 1'($urandom),
            {$urandom, $urandom} & {$urandom, $urandom},
            {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    end
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule